// File: doc/BRIEF.md
# Parallel Port Configuration and Latch Register

This block is the processor-facing register interface of a three-port, 24-line programmable parallel I/O unit. A host reaches it through an active-low chip select, an active-low read strobe, an active-low write strobe, a 2-bit port address and an 8-bit data bus. The block keeps the output latches of ports A, B and C and the configuration of the two port groups. It decodes control writes either into a new configuration or into a command that sets or clears one port C bit. It drives read data with a separate output enable, so the pad ring can build the tri-state buffer. The direction and mode outputs steer the pad drivers and the handshake logic outside this block. A one-cycle reload pulse tells that logic to clear its status and interrupt-enable flops.

The host strobes are asynchronous. Each one passes through a two-stage synchronizer. A write takes effect at the clock edge that follows detection of the rising edge of the synchronized write strobe. Group A covers port A and the upper nibble of port C. Group B covers port B and the lower nibble of port C.

Top module: `ppi_ctrl_regs`

## Requirements
- R1: After reset, all four direction outputs read 1 (input). Both group modes are 0, all three output latches are 0x00, `dout_oe` is 0 and `cfg_reload` is 0.
- R2: A committed write stores `din` at the addressed port: address 0 goes to port A and address 1 goes to port B. Address 2 goes to port C, within the limits of R9. Address 3 is the control address.
- R3: A write commits at the third rising clock edge after `wr_n` returns high, if `cs_n` and `wr_n` were both low together for at least three edges. `din` and `addr` must stay stable until the commit. A write made with `cs_n` high changes nothing.
- R4: A control write with `din[7]=1` loads the configuration. `din[6:5]` sets the group A mode, `din[4]` sets port A direction and `din[3]` sets port C upper direction. `din[2]` sets the group B mode, `din[1]` sets port B direction and `din[0]` sets port C lower direction. A direction bit of 1 means input. The configuration changes only through such a write.
- R5: A configuration write clears all three output latches to 0x00. In the same cycle, `cfg_reload` goes high for exactly one cycle.
- R6: A control write with `din[7]=0` is a single-bit command. `din[3:1]` selects the port C bit and `din[0]` gives the new value (1 = set). No other latch bit changes, the configuration stays the same and `cfg_reload` stays low.
- R7: `dout_oe` goes high two rising edges after `cs_n` and `rd_n` are both low, unless `addr` is 3. The control address can never be read. With `cs_n` high, `dout_oe` stays low.
- R8: A read of a port set to input returns the live pin value. A read of a port set to output returns its latch. Port C chooses per nibble.
- R9: A direct write to port C always updates the lower nibble. It updates the upper nibble only while group A is in mode 0.
- R10: Group A mode codes are: 00 = mode 0, 01 = mode 1, 10 and 11 = mode 2 (`grp_a_mode` reads 2). In mode 2, a read of port A returns the pins whatever the port A direction bit says.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| rd_n | input | 1 | Read strobe, active low, asynchronous |
| wr_n | input | 1 | Write strobe, active low, asynchronous |
| addr | input | 2 | Port / control address |
| din | input | 8 | Write data from host bus |
| dout | output | 8 | Read data to host bus (0 when not enabled) |
| dout_oe | output | 1 | Output enable for host bus buffer |
| pa_pin | input | 8 | Port A pin levels |
| pb_pin | input | 8 | Port B pin levels |
| pc_pin | input | 8 | Port C pin levels |
| pa_q | output | 8 | Port A output latch |
| pb_q | output | 8 | Port B output latch |
| pc_q | output | 8 | Port C output latch |
| pa_is_in | output | 1 | Port A direction, 1 = input |
| pb_is_in | output | 1 | Port B direction, 1 = input |
| pcu_is_in | output | 1 | Port C upper nibble direction, 1 = input |
| pcl_is_in | output | 1 | Port C lower nibble direction, 1 = input |
| grp_a_mode | output | 2 | Group A mode 0, 1 or 2 |
| grp_b_mode | output | 1 | Group B mode 0 or 1 |
| cfg_reload | output | 1 | One-cycle pulse on every configuration write |

## Verification
A write's effects show up on the latches, the configuration outputs and `cfg_reload` right after the third rising edge that follows the release of `wr_n`. `cfg_reload` falls again one edge later. The read enable and read data are valid after the second rising edge that follows the assertion of `rd_n`. Each bus task changes its strobes on a falling edge and counts those rising edges. It samples on the next falling edge, so every check lands in the first cycle where the result is due.

// File: rtl/ppi_pkg.sv
package ppi_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned HALF_W = DATA_W / 2;
  localparam int unsigned SEL_W  = $clog2(DATA_W);

  localparam logic [1:0] ADR_PA   = 2'd0;
  localparam logic [1:0] ADR_PB   = 2'd1;
  localparam logic [1:0] ADR_PC   = 2'd2;
  localparam logic [1:0] ADR_CTRL = 2'd3;

  typedef enum logic [1:0] {
    GA_BASIC   = 2'd0,
    GA_STROBED = 2'd1,
    GA_BIDIR   = 2'd2
  } ga_mode_e;

  typedef struct packed {
    ga_mode_e mode_a;
    logic     a_in;
    logic     cu_in;
    logic     mode_b;
    logic     b_in;
    logic     cl_in;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{mode_a: GA_BASIC, a_in: 1'b1, cu_in: 1'b1,
                                 mode_b: 1'b0, b_in: 1'b1, cl_in: 1'b1};
endpackage

// File: rtl/ppi_sync.sv
module ppi_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= {W{RST_VAL}};
        else        stg[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= {W{RST_VAL}};
        else        stg[g] <= stg[g-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/ppi_cfg_regs.sv
module ppi_cfg_regs
  import ppi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] din,
  output cfg_t              cfg,
  output logic [DATA_W-1:0] pa_q,
  output logic [DATA_W-1:0] pb_q,
  output logic [DATA_W-1:0] pc_q,
  output logic              reload
);
  cfg_t              cfg_n;
  logic [DATA_W-1:0] pa_n, pb_n, pc_n;
  logic              reload_n;

  always_comb begin
    cfg_n    = cfg;
    pa_n     = pa_q;
    pb_n     = pb_q;
    pc_n     = pc_q;
    reload_n = 1'b0;
    if (commit) begin
      unique case (addr)
        ADR_PA: pa_n = din;
        ADR_PB: pb_n = din;
        ADR_PC: begin
          pc_n[HALF_W-1:0] = din[HALF_W-1:0];
          if (cfg.mode_a == GA_BASIC) pc_n[DATA_W-1:HALF_W] = din[DATA_W-1:HALF_W];
        end
        default: begin
          if (din[7]) begin
            cfg_n.mode_a = din[6] ? GA_BIDIR : (din[5] ? GA_STROBED : GA_BASIC);
            cfg_n.a_in   = din[4];
            cfg_n.cu_in  = din[3];
            cfg_n.mode_b = din[2];
            cfg_n.b_in   = din[1];
            cfg_n.cl_in  = din[0];
            pa_n         = '0;
            pb_n         = '0;
            pc_n         = '0;
            reload_n     = 1'b1;
          end else begin
            pc_n[din[SEL_W:1]] = din[0];
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg  <= CFG_RESET;
      pa_q <= '0;
      pb_q <= '0;
      pc_q <= '0;
    end else if (commit) begin
      cfg  <= cfg_n;
      pa_q <= pa_n;
      pb_q <= pb_n;
      pc_q <= pc_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reload <= 1'b0;
    else        reload <= reload_n;
  end
endmodule

// File: rtl/ppi_rd_mux.sv
module ppi_rd_mux
  import ppi_pkg::*;
(
  input  cfg_t              cfg,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] pa_pin,
  input  logic [DATA_W-1:0] pb_pin,
  input  logic [DATA_W-1:0] pc_pin,
  input  logic [DATA_W-1:0] pa_q,
  input  logic [DATA_W-1:0] pb_q,
  input  logic [DATA_W-1:0] pc_q,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] pc_view;

  always_comb begin
    pc_view[DATA_W-1:HALF_W] = cfg.cu_in ? pc_pin[DATA_W-1:HALF_W] : pc_q[DATA_W-1:HALF_W];
    pc_view[HALF_W-1:0]      = cfg.cl_in ? pc_pin[HALF_W-1:0] : pc_q[HALF_W-1:0];
    unique case (addr)
      ADR_PA:  rd_data = (cfg.a_in || cfg.mode_a == GA_BIDIR) ? pa_pin : pa_q;
      ADR_PB:  rd_data = cfg.b_in ? pb_pin : pb_q;
      ADR_PC:  rd_data = pc_view;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/ppi_ctrl_regs.sv
module ppi_ctrl_regs
  import ppi_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic [1:0] addr,
  input  logic [7:0] din,
  output logic [7:0] dout,
  output logic       dout_oe,
  input  logic [7:0] pa_pin,
  input  logic [7:0] pb_pin,
  input  logic [7:0] pc_pin,
  output logic [7:0] pa_q,
  output logic [7:0] pb_q,
  output logic [7:0] pc_q,
  output logic       pa_is_in,
  output logic       pb_is_in,
  output logic       pcu_is_in,
  output logic       pcl_is_in,
  output logic [1:0] grp_a_mode,
  output logic       grp_b_mode,
  output logic       cfg_reload
);
  logic       rst_q_n;
  logic [2:0] strb_s;
  logic       cs_s, rd_s, wr_s;
  logic       wr_d, armed, armed_n, commit;
  cfg_t       cfg;
  logic [7:0] rd_data;

  ppi_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_q_n)
  );

  ppi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_strb_sync (
    .clk(clk), .rst_n(rst_q_n), .d({cs_n, rd_n, wr_n}), .q(strb_s)
  );
  assign {cs_s, rd_s, wr_s} = strb_s;

  // write trailing-edge detection, qualified by a select seen while low
  assign commit = wr_s && !wr_d && armed;

  always_comb begin
    armed_n = armed;
    if (commit)               armed_n = 1'b0;
    else if (!wr_s && !cs_s)  armed_n = 1'b1;
    else if (wr_s)            armed_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      wr_d  <= 1'b1;
      armed <= 1'b0;
    end else begin
      wr_d  <= wr_s;
      armed <= armed_n;
    end
  end

  ppi_cfg_regs u_cfg (
    .clk(clk), .rst_n(rst_q_n), .commit(commit), .addr(addr), .din(din),
    .cfg(cfg), .pa_q(pa_q), .pb_q(pb_q), .pc_q(pc_q), .reload(cfg_reload)
  );

  ppi_rd_mux u_rd (
    .cfg(cfg), .addr(addr), .pa_pin(pa_pin), .pb_pin(pb_pin), .pc_pin(pc_pin),
    .pa_q(pa_q), .pb_q(pb_q), .pc_q(pc_q), .rd_data(rd_data)
  );

  assign dout_oe    = !cs_s && !rd_s && (addr != ADR_CTRL);
  assign dout       = dout_oe ? rd_data : '0;
  assign pa_is_in   = cfg.a_in;
  assign pb_is_in   = cfg.b_in;
  assign pcu_is_in  = cfg.cu_in;
  assign pcl_is_in  = cfg.cl_in;
  assign grp_a_mode = cfg.mode_a;
  assign grp_b_mode = cfg.mode_b;
endmodule

// File: rtl/ppi_ctrl_regs_chk.sv
module ppi_ctrl_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       rd_n,
  input logic       dout_oe,
  input logic [7:0] pa_q,
  input logic [7:0] pb_q,
  input logic [7:0] pc_q,
  input logic       pa_is_in,
  input logic       pb_is_in,
  input logic       pcu_is_in,
  input logic       pcl_is_in,
  input logic [1:0] grp_a_mode,
  input logic       grp_b_mode,
  input logic       cfg_reload
);
  p_reload_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_reload |=> !cfg_reload);

  p_reload_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_reload |-> (pa_q == 8'h00 && pb_q == 8'h00 && pc_q == 8'h00));

  p_cfg_only_on_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_reload |-> $stable({grp_a_mode, grp_b_mode, pa_is_in, pb_is_in, pcu_is_in, pcl_is_in}));

  p_oe_needs_rd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dout_oe |-> (!$past(rd_n, 2) && !$past(cs_n, 2)));

  p_idle_no_oe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2)) |-> !dout_oe);

  p_mode_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
    grp_a_mode != 2'b11);
endmodule

bind ppi_ctrl_regs ppi_ctrl_regs_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .dout_oe(dout_oe),
  .pa_q(pa_q), .pb_q(pb_q), .pc_q(pc_q), .pa_is_in(pa_is_in), .pb_is_in(pb_is_in),
  .pcu_is_in(pcu_is_in), .pcl_is_in(pcl_is_in), .grp_a_mode(grp_a_mode),
  .grp_b_mode(grp_b_mode), .cfg_reload(cfg_reload)
);

// File: tb/ppi_ctrl_regs_tb_top.sv
module ppi_ctrl_regs_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = 2'd0;
  logic [7:0] din = 8'h00;
  logic [7:0] pa_pin = 8'h00, pb_pin = 8'h00, pc_pin = 8'h00;
  logic [7:0] dout, pa_q, pb_q, pc_q;
  logic       dout_oe, pa_is_in, pb_is_in, pcu_is_in, pcl_is_in, grp_b_mode, cfg_reload;
  logic [1:0] grp_a_mode;

  int checks = 0;
  int errors = 0;
  logic last_reload;

  always #2 clk = ~clk;

  ppi_ctrl_regs dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
    .din(din), .dout(dout), .dout_oe(dout_oe), .pa_pin(pa_pin), .pb_pin(pb_pin),
    .pc_pin(pc_pin), .pa_q(pa_q), .pb_q(pb_q), .pc_q(pc_q), .pa_is_in(pa_is_in),
    .pb_is_in(pb_is_in), .pcu_is_in(pcu_is_in), .pcl_is_in(pcl_is_in),
    .grp_a_mode(grp_a_mode), .grp_b_mode(grp_b_mode), .cfg_reload(cfg_reload)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // strobes change on falling edges; results sampled on falling edges
  task automatic bus_write(input logic [1:0] a, input logic [7:0] d, input logic sel_n);
    @(negedge clk);
    cs_n = sel_n; addr = a; din = d; wr_n = 1'b0;
    repeat (4) @(negedge clk);
    wr_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    last_reload = cfg_reload;
    cs_n = 1'b1;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d, output logic oe);
    @(negedge clk);
    cs_n = 1'b0; addr = a; rd_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    d = dout; oe = dout_oe;
    rd_n = 1'b1; cs_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1", "pa_is_in", pa_is_in, 1); chk("R1", "pb_is_in", pb_is_in, 1);
    chk("R1", "pcu_is_in", pcu_is_in, 1); chk("R1", "pcl_is_in", pcl_is_in, 1);
    chk("R1", "grp_a_mode", grp_a_mode, 0); chk("R1", "grp_b_mode", grp_b_mode, 0);
    chk("R1", "latches", {pa_q, pb_q, pc_q}, 0);
    chk("R1", "dout_oe", dout_oe, 0); chk("R1", "cfg_reload", cfg_reload, 0);
  endtask

  task automatic t_port_writes;
    logic [7:0] d; logic oe;
    bus_write(2'd3, 8'h80, 1'b0);
    chk("R4", "all outputs", {pa_is_in, pb_is_in, pcu_is_in, pcl_is_in}, 0);
    bus_write(2'd0, 8'h5A, 1'b0); chk("R2", "pa_q", pa_q, 8'h5A);
    bus_write(2'd1, 8'hC3, 1'b0); chk("R2", "pb_q", pb_q, 8'hC3);
    bus_write(2'd2, 8'h96, 1'b0); chk("R2", "pc_q", pc_q, 8'h96);
    chk("R3", "no reload on data write", last_reload, 0);
    bus_read(2'd0, d, oe);
    chk("R7", "oe port A", oe, 1); chk("R8", "read A latch", d, 8'h5A);
    bus_read(2'd2, d, oe); chk("R8", "read C latch", d, 8'h96);
  endtask

  task automatic t_cs_ignore;
    logic [7:0] d; logic oe;
    bus_write(2'd0, 8'hFF, 1'b1); chk("R3", "cs high write", pa_q, 8'h5A);
    @(negedge clk); addr = 2'd0; rd_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7", "cs high read oe", dout_oe, 0);
    rd_n = 1'b1; repeat (3) @(negedge clk);
    bus_read(2'd3, d, oe); chk("R7", "control read oe", oe, 0);
  endtask

  task automatic t_mode_clear;
    bus_write(2'd3, 8'h9B, 1'b0);
    chk("R5", "reload pulse", last_reload, 1);
    chk("R5", "latches cleared", {pa_q, pb_q, pc_q}, 0);
    @(negedge clk); chk("R5", "reload one cycle", cfg_reload, 0);
    chk("R4", "dirs 0x9B", {pa_is_in, pcu_is_in, pb_is_in, pcl_is_in}, 4'b1111);
  endtask

  task automatic t_live_read;
    logic [7:0] d; logic oe;
    pa_pin = 8'h33; pb_pin = 8'h44; pc_pin = 8'hE7;
    bus_read(2'd0, d, oe); chk("R8", "read A pins", d, 8'h33);
    bus_read(2'd1, d, oe); chk("R8", "read B pins", d, 8'h44);
    bus_write(2'd3, 8'h81, 1'b0);
    bus_write(2'd2, 8'h5C, 1'b0);
    bus_read(2'd2, d, oe); chk("R8", "read C split nibbles", d, 8'h57);
  endtask

  task automatic t_bsr;
    bus_write(2'd3, 8'h80, 1'b0);
    bus_write(2'd3, 8'h0B, 1'b0);
    chk("R6", "set bit5", pc_q, 8'h20); chk("R6", "no reload", last_reload, 0);
    bus_write(2'd3, 8'h0F, 1'b0); chk("R6", "set bit7", pc_q, 8'hA0);
    bus_write(2'd3, 8'h0A, 1'b0); chk("R6", "clear bit5", pc_q, 8'h80);
    bus_write(2'd3, 8'h01, 1'b0); chk("R6", "set bit0", pc_q, 8'h81);
    chk("R6", "cfg kept", {grp_a_mode, pa_is_in, pcu_is_in, grp_b_mode, pb_is_in, pcl_is_in}, 0);
  endtask

  task automatic t_fields;
    bus_write(2'd3, 8'hA4, 1'b0);
    chk("R4", "mode A 1", grp_a_mode, 1); chk("R4", "mode B 1", grp_b_mode, 1);
    chk("R4", "dirs 0xA4", {pa_is_in, pcu_is_in, pb_is_in, pcl_is_in}, 0);
    bus_write(2'd2, 8'hFF, 1'b0); chk("R9", "upper blocked", pc_q, 8'h0F);
    bus_write(2'd3, 8'hD2, 1'b0);
    chk("R10", "mode A 10", grp_a_mode, 2);
    chk("R4", "dirs 0xD2", {pa_is_in, pcu_is_in, pb_is_in, pcl_is_in}, 4'b1010);
    bus_write(2'd3, 8'hE0, 1'b0); chk("R10", "mode A 11", grp_a_mode, 2);
    bus_write(2'd3, 8'h80, 1'b0);
    bus_write(2'd2, 8'hFF, 1'b0); chk("R9", "mode0 full write", pc_q, 8'hFF);
  endtask

  task automatic t_bidir_read;
    logic [7:0] d; logic oe;
    bus_write(2'd3, 8'hC0, 1'b0);
    bus_write(2'd0, 8'h11, 1'b0);
    pa_pin = 8'h77;
    bus_read(2'd0, d, oe); chk("R10", "mode2 reads pins", d, 8'h77);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_port_writes;
    t_cs_ignore;
    t_mode_clear;
    t_live_read;
    t_bsr;
    t_fields;
    t_bidir_read;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule